// File: doc/BRIEF.md
# Unaligned Word Load/Store Merger

This unit does the byte splicing for the four partial-word instructions of a little-endian core: load-left, load-right, store-left and store-right. Each one moves a group of bytes that can straddle a word boundary. The unit takes the instruction kind, the effective byte address, the current value of the register involved and the aligned memory word. It returns one spliced 32-bit word. For a load, that word goes back to the register file. For a store, it goes back to memory.

The low two address bits pick which byte lanes come from the register and which come from memory. Memory is always addressed at the word-aligned address, so a store is a read-modify-write: the caller reads the aligned word, passes it in, and writes back what the unit returns. Results are registered and appear one cycle after an input strobe, together with a valid flag and a write strobe for either the register file or memory.

Top module: `word_splice_unit`

## Requirements
- R1: The output address is the input effective address with its two low bits forced to zero, for every kind.
- R2: Load-left (kind code 0) at byte offset k: result bytes 3-k up to 3 hold memory bytes 0 up to k, in order. The lower result bytes keep the register's bytes. Offset 0 puts memory byte 0 in the top byte; offset 3 returns the memory word.
- R3: Load-right (kind code 1) at byte offset k: result bytes 0 up to 3-k hold memory bytes k up to 3. The upper result bytes keep the register's bytes. Offset 0 returns the memory word; offset 3 puts memory byte 3 in byte 0 under the register's top three bytes.
- R4: Store-left (kind code 2) at byte offset k: written bytes 0 up to k hold register bytes 3-k up to 3. The upper bytes keep the memory word's bytes. Offset 3 writes the whole register.
- R5: Store-right (kind code 3) at byte offset k: written bytes k up to 3 hold register bytes 0 up to 3-k. The lower bytes keep the memory word's bytes. Offset 0 writes the whole register.
- R6: A load whose destination register index is 0 still yields a valid output, but its register write enable stays low.
- R7: The output valid flag is high exactly in the cycle after an accepted input strobe, and low after a cycle with no strobe.
- R8: A load raises only the register write enable (destination index not zero). A store raises only the memory write enable. Neither enable is high while the output valid flag is low.
- R9: A synchronous active-high reset clears the output valid flag and both write enables, even when an input strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input strobe |
| in_kind | input | 2 | 0 load-left, 1 load-right, 2 store-left, 3 store-right |
| in_addr | input | AW | Effective byte address |
| in_dst | input | RW | Destination register index (loads) |
| in_reg | input | 32 | Current register value |
| in_mem | input | 32 | Memory word read at the aligned address |
| out_valid | output | 1 | Result valid |
| out_reg_we | output | 1 | Register file write enable |
| out_mem_we | output | 1 | Memory write enable |
| out_addr | output | AW | Word-aligned address |
| out_data | output | 32 | Spliced word |

## Verification
The bench covers all sixteen pairs of kind and offset, using byte patterns where every lane is distinct. A design that mirrored a shift amount, or swapped the left and right masks, would show a byte in the wrong lane or a stale register byte at offsets 1 and 2, even where offsets 0 and 3 still look right. Random addresses with nonzero low bits catch an output address that was not cleared. Loads that target register zero catch a write enable that ignores the destination index. A reset asserted in the same cycle as a strobe catches strobes that survive reset. Idle gaps catch a valid flag that stays high after its input has gone.

// File: rtl/word_splice_unit.sv
module word_splice_unit #(
  parameter int AW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    in_kind,
  input  logic [AW-1:0] in_addr,
  input  logic [RW-1:0] in_dst,
  input  logic [31:0]   in_reg,
  input  logic [31:0]   in_mem,
  output logic          out_valid,
  output logic          out_reg_we,
  output logic          out_mem_we,
  output logic [AW-1:0] out_addr,
  output logic [31:0]   out_data
);

  localparam logic [31:0] LO3 = 32'h00FF_FFFF;
  localparam logic [31:0] HI3 = 32'hFFFF_FF00;

  logic        is_load;
  logic [4:0]  sh, shc;
  logic [31:0] merged;

  assign is_load = ~in_kind[1];
  assign sh      = {in_addr[1:0], 3'b000};
  assign shc     = 5'd24 - sh;

  always_comb begin
    case (in_kind)
      2'd0:    merged = (in_mem << shc) | (in_reg & (LO3 >> sh));
      2'd1:    merged = (in_mem >> sh)  | (in_reg & (HI3 << shc));
      2'd2:    merged = (in_reg >> shc) | (in_mem & (HI3 << sh));
      default: merged = (in_reg << sh)  | (in_mem & (LO3 >> shc));
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_reg_we <= 1'b0;
      out_mem_we <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      out_reg_we <= in_valid & is_load & (|in_dst);
      out_mem_we <= in_valid & ~is_load;
    end
    if (in_valid) begin
      out_data <= merged;
      out_addr <= {in_addr[AW-1:2], 2'b00};
    end
  end

  // R1
  aligned_addr_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_addr[1:0] == 2'b00));

  // R2
  load_left_full_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 2'd0 && in_addr[1:0] == 2'd3) |=> (out_data == $past(in_mem)));

  // R3
  load_right_full_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 2'd1 && in_addr[1:0] == 2'd0) |=> (out_data == $past(in_mem)));

  // R4
  store_left_full_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 2'd2 && in_addr[1:0] == 2'd3) |=> (out_data == $past(in_reg)));

  // R5
  store_right_full_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 2'd3 && in_addr[1:0] == 2'd0) |=> (out_data == $past(in_reg)));

  // R6
  zero_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_kind[1] && in_dst == '0) |=> (out_valid && !out_reg_we));

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R8
  strobe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (out_reg_we || out_mem_we) |-> out_valid);

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({out_reg_we, out_mem_we}) <= 1);

endmodule

// File: tb/sim_word_splice_unit.sv
`timescale 1ns/1ps
module sim_word_splice_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_kind = '0;
  logic [31:0] in_addr = '0;
  logic [4:0]  in_dst = '0;
  logic [31:0] in_reg = '0, in_mem = '0;
  logic        out_valid, out_reg_we, out_mem_we;
  logic [31:0] out_addr, out_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct packed {
    logic [31:0] d;
    logic [31:0] a;
    logic        rwe;
    logic        mwe;
  } exp_t;
  exp_t  eq[$];
  string tq[$];

  always #2.5 clk = ~clk;

  word_splice_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
    .in_addr(in_addr), .in_dst(in_dst), .in_reg(in_reg), .in_mem(in_mem),
    .out_valid(out_valid), .out_reg_we(out_reg_we), .out_mem_we(out_mem_we),
    .out_addr(out_addr), .out_data(out_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [1:0] kind, input int k,
                                        input logic [31:0] r, input logic [31:0] m);
    logic [31:0] res;
    for (int i = 0; i < 4; i++) begin
      case (kind)
        2'd0: res[i*8 +: 8] = (i >= 3 - k) ? m[(i - (3 - k))*8 +: 8] : r[i*8 +: 8];
        2'd1: res[i*8 +: 8] = (i <= 3 - k) ? m[(i + k)*8 +: 8]       : r[i*8 +: 8];
        2'd2: res[i*8 +: 8] = (i <= k)     ? r[(i + 3 - k)*8 +: 8]   : m[i*8 +: 8];
        default: res[i*8 +: 8] = (i >= k)  ? r[(i - k)*8 +: 8]       : m[i*8 +: 8];
      endcase
    end
    return res;
  endfunction

  task automatic send(input logic [1:0] kind, input logic [31:0] addr,
                      input logic [4:0] dst, input logic [31:0] r, input logic [31:0] m);
    exp_t e;
    string t;
    @(negedge clk);
    in_valid = 1'b1; in_kind = kind; in_addr = addr; in_dst = dst; in_reg = r; in_mem = m;
    e.d   = model(kind, int'(addr[1:0]), r, m);
    e.a   = {addr[31:2], 2'b00};
    e.rwe = !kind[1] && dst != 0;
    e.mwe = kind[1];
    case (kind)
      2'd0: t = "R2";
      2'd1: t = "R3";
      2'd2: t = "R4";
      default: t = "R5";
    endcase
    if (!kind[1] && dst == 0) t = {t, "/R6"};
    eq.push_back(e);
    tq.push_back(t);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (eq.size() == 0) begin
          chk("R7 unexpected valid", 32'd1, 32'd0);
        end else begin
          exp_t  e;
          string t;
          e = eq.pop_front();
          t = tq.pop_front();
          chk({t, " data"}, out_data, e.d);
          chk("R1 addr", out_addr, e.a);
          chk({"R8 reg_we ", t}, {31'd0, out_reg_we}, {31'd0, e.rwe});
          chk("R8 mem_we", {31'd0, out_mem_we}, {31'd0, e.mwe});
        end
      end else begin
        chk("R8 strobes while idle", {30'd0, out_reg_we, out_mem_we}, 32'd0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R9 reset strobes", {30'd0, out_reg_we, out_mem_we}, 32'd0);
    rst = 1'b0;

    for (int kind = 0; kind < 4; kind++)
      for (int off = 0; off < 4; off++) begin
        send(2'(kind), 32'h1000_0040 + 32'(off), 5'd7, 32'hAABB_CCDD, 32'h1122_3344);
        send(2'(kind), 32'hFFFF_FFF0 + 32'(off), 5'd31, 32'h0102_0304, 32'hF0E0_D0C0);
      end

    send(2'd0, 32'h0000_0101, 5'd0, 32'h1234_5678, 32'h9ABC_DEF0);
    send(2'd1, 32'h0000_0202, 5'd0, 32'h1234_5678, 32'h9ABC_DEF0);
    send(2'd2, 32'h0000_0303, 5'd0, 32'h1234_5678, 32'h9ABC_DEF0);

    idle(3);
    chk("R7 queue drained", 32'(eq.size()), 32'd0);
    chk("R7 valid after gap", {31'd0, out_valid}, 32'd0);

    for (int i = 0; i < 40; i++) begin
      send(2'($urandom_range(0, 3)), $urandom, 5'($urandom_range(0, 31)), $urandom, $urandom);
      if (i % 7 == 3) idle(1);
    end
    idle(3);

    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_kind = 2'd2; in_addr = 32'h40; in_dst = 5'd3;
    @(negedge clk);
    chk("R9 valid under reset", {31'd0, out_valid}, 32'd0);
    chk("R9 strobes under reset", {30'd0, out_reg_we, out_mem_we}, 32'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    idle(2);
    chk("R7 queue drained at end", 32'(eq.size()), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule